// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer

This block is a 16-bit timer that advances once per qualifying cycle, marked by a count-enable tick. A companion 16-bit reload register supplies the restart value. When the bidirectional feature is switched off, the timer only counts upward. When the count passes all ones, it wraps to the reload value. When the feature is switched on, an external direction pin picks the counting direction per tick. Counting down, the terminal point is reached when the count equals the reload value, and the timer then restarts at all ones.

Every terminal event does three things: it sets a sticky interrupt flag, it reloads the counter, and it inverts a wrap toggle bit. The toggle bit acts as a seventeenth count bit for software or neighbouring logic and raises no interrupt of its own. Software can write the counter and the reload register directly and can clear the flag.

Top module: `updown_reload_timer`

## Requirements
- R1: With `dir_en_i` low, each tick increments the count by one, whatever level `dir_up_i` has.
- R2: With `dir_en_i` high, each tick increments the count when `dir_up_i` is 1 and decrements it when `dir_up_i` is 0.
- R3: Counting up, a tick at count 16'hFFFF loads the reload value into the counter and sets `irq_flag_o`.
- R4: Counting down, a tick at a count equal to the reload value loads 16'hFFFF and sets `irq_flag_o`. A tick at count 0 that does not match the reload value simply wraps to 16'hFFFF and produces no event.
- R5: `wrap_tgl_o` inverts on every terminal event (R3, R4) and holds its level in all other cycles.
- R6: In a cycle with `tick_i` low and no counter write, the count does not change.
- R7: A counter write (`cnt_we_i`) loads `cnt_wdata_i` even when a tick arrives in the same cycle. Such a cycle produces no terminal event.
- R8: `irq_flag_o` stays set until `flag_clr_i` is applied. When a clear and a terminal event fall in the same cycle, the flag ends up set.
- R9: A reload write (`rld_we_i`) changes only the reload register. A terminal event in the same cycle reloads the previous reload value.
- R10: Synchronous reset `rst` clears the count, the reload register, the flag and the toggle bit.
- R11: All register updates take effect at the rising clock edge, and the outputs show the new state right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable for this cycle |
| dir_up_i | input | 1 | Direction pin: 1 counts up, 0 counts down (used only when dir_en_i is 1) |
| dir_en_i | input | 1 | Enables the bidirectional feature |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 16 | Counter write data |
| rld_we_i | input | 1 | Reload register write strobe |
| rld_wdata_i | input | 16 | Reload register write data |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| count_o | output | 16 | Current count |
| irq_flag_o | output | 1 | Sticky terminal-event flag |
| wrap_tgl_o | output | 1 | Toggle bit, inverted on each terminal event |

## Verification
The hardest cases to reach are the ones where several actions land in one cycle. These are a terminal event together with a reload write, a flag clear, or a counter write, and a down-count that passes through zero while the reload value is nonzero. Counting to a terminal point one tick at a time would take up to 65536 cycles. Instead, the stimulus presets the counter with a direct write to one step before the terminal point. It then applies the colliding strobes in the same vector as the final tick, so each collision is set up in two or three cycles.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic hit;
        dir_e dir;
    } term_t;

    function automatic dir_e pick_dir(input logic feature_on, input logic pin_up);
        if (feature_on && !pin_up) begin
            return DIR_DOWN;
        end
        return DIR_UP;
    endfunction

endpackage

// File: rtl/tmr_step_calc.sv
module tmr_step_calc
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] rld_i,
    input  dir_e         dir_i,
    input  logic         tick_i,
    input  logic         wr_i,
    output logic [W-1:0] nxt_o,
    output term_t        ev_o
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ONE      = W'(1);

    logic at_top;
    logic at_rld;

    assign at_top = (cur_i == ALL_ONES);
    assign at_rld = (cur_i == rld_i);

    always_comb begin
        nxt_o      = cur_i;
        ev_o.hit   = 1'b0;
        ev_o.dir   = dir_i;
        if (tick_i && !wr_i) begin
            if (dir_i == DIR_UP) begin
                if (at_top) begin
                    nxt_o    = rld_i;
                    ev_o.hit = 1'b1;
                end else begin
                    nxt_o    = cur_i + ONE;
                end
            end else begin
                if (at_rld) begin
                    nxt_o    = ALL_ONES;
                    ev_o.hit = 1'b1;
                end else begin
                    nxt_o    = cur_i - ONE;
                end
            end
        end
    end

endmodule

// File: rtl/tmr_event_flags.sv
module tmr_event_flags
    import timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  term_t ev_i,
    input  logic  clr_i,
    output logic  flag_o,
    output logic  tgl_o
);
    logic flag_q;
    logic tgl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            tgl_q  <= 1'b0;
        end else begin
            if (ev_i.hit) begin
                flag_q <= 1'b1;
            end else if (clr_i) begin
                flag_q <= 1'b0;
            end
            if (ev_i.hit) begin
                tgl_q <= ~tgl_q;
            end
        end
    end

    assign flag_o = flag_q;
    assign tgl_o  = tgl_q;

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> flag_q);

    p_clr_loses_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_i.hit && clr_i) |=> flag_q);

    p_tgl_flip_r5: assert property (@(posedge clk) disable iff (rst)
        ev_i.hit |=> (tgl_q != $past(tgl_q)));

    p_tgl_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ev_i.hit |=> $stable(tgl_q));

endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         dir_up_i,
    input  logic         dir_en_i,
    input  logic         cnt_we_i,
    input  logic [W-1:0] cnt_wdata_i,
    input  logic         rld_we_i,
    input  logic [W-1:0] rld_wdata_i,
    input  logic         flag_clr_i,
    output logic [W-1:0] count_o,
    output logic         irq_flag_o,
    output logic         wrap_tgl_o
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] count_q;
    logic [W-1:0] reload_q;
    logic [W-1:0] count_nxt;
    dir_e         cur_dir;
    term_t        ev;

    assign cur_dir = pick_dir(dir_en_i, dir_up_i);

    tmr_step_calc #(.W(W)) step_i (
        .cur_i  (count_q),
        .rld_i  (reload_q),
        .dir_i  (cur_dir),
        .tick_i (tick_i),
        .wr_i   (cnt_we_i),
        .nxt_o  (count_nxt),
        .ev_o   (ev)
    );

    tmr_event_flags flags_i (
        .clk    (clk),
        .rst    (rst),
        .ev_i   (ev),
        .clr_i  (flag_clr_i),
        .flag_o (irq_flag_o),
        .tgl_o  (wrap_tgl_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            count_q <= cnt_we_i ? cnt_wdata_i : count_nxt;
            if (rld_we_i) begin
                reload_q <= rld_wdata_i;
            end
        end
    end

    assign count_o = count_q;

    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !cnt_we_i) |=> $stable(count_o));

    p_write_prio_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_we_i |=> (count_o == $past(cnt_wdata_i)));

    p_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !cnt_we_i && cur_dir == DIR_UP && count_o == ALL_ONES)
        |=> (count_o == $past(reload_q)) && irq_flag_o);

    p_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !cnt_we_i && cur_dir == DIR_DOWN && count_o == reload_q)
        |=> (count_o == ALL_ONES) && irq_flag_o);

    p_up_only_r1: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !cnt_we_i && !dir_en_i && count_o != ALL_ONES)
        |=> (count_o == $past(count_o) + W'(1)));

endmodule

// File: tb/updown_reload_timer_tb.sv
module updown_reload_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_i, dir_up_i, dir_en_i, cnt_we_i, rld_we_i, flag_clr_i;
    logic [15:0] cnt_wdata_i, rld_wdata_i;
    logic [15:0] count_o;
    logic        irq_flag_o, wrap_tgl_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    updown_reload_timer #(.W(16)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .dir_up_i    (dir_up_i),
        .dir_en_i    (dir_en_i),
        .cnt_we_i    (cnt_we_i),
        .cnt_wdata_i (cnt_wdata_i),
        .rld_we_i    (rld_we_i),
        .rld_wdata_i (rld_wdata_i),
        .flag_clr_i  (flag_clr_i),
        .count_o     (count_o),
        .irq_flag_o  (irq_flag_o),
        .wrap_tgl_o  (wrap_tgl_o)
    );

    typedef struct packed {
        logic        tick;
        logic        up;
        logic        en;
        logic        cwe;
        logic [15:0] cwd;
        logic        rwe;
        logic [15:0] rwd;
        logic        clr;
        logic [15:0] ecnt;
        logic        eflag;
        logic        etgl;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        // R9: reload write leaves counter alone
        '{1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,16'h1234,1'b0,16'h0000,1'b0,1'b0,8'd9},
        // R7: preset counter
        '{1'b0,1'b0,1'b0,1'b1,16'hFFFE,1'b0,16'h0000,1'b0,16'hFFFE,1'b0,1'b0,8'd7},
        // R1: up count
        '{1'b1,1'b0,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'hFFFF,1'b0,1'b0,8'd1},
        // R3: overflow reloads, sets flag, toggles
        '{1'b1,1'b0,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h1234,1'b1,1'b1,8'd3},
        // R6: no tick holds
        '{1'b0,1'b1,1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h1234,1'b1,1'b1,8'd6},
        // R8: clear flag
        '{1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,16'h1234,1'b0,1'b1,8'd8},
        // R2: pin high counts up
        '{1'b1,1'b1,1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h1235,1'b0,1'b1,8'd2},
        // R2: pin low counts down
        '{1'b1,1'b0,1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h1234,1'b0,1'b1,8'd2},
        // R4: equal to reload going down
        '{1'b1,1'b0,1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'hFFFF,1'b1,1'b0,8'd4},
        // R8: clear without event
        '{1'b1,1'b0,1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b1,16'hFFFE,1'b0,1'b0,8'd8},
        // R1: pin ignored when feature off
        '{1'b1,1'b0,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'hFFFF,1'b0,1'b0,8'd1},
        // R8: clear loses to event
        '{1'b1,1'b0,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,16'h1234,1'b1,1'b1,8'd8},
        // R7: write beats tick
        '{1'b1,1'b0,1'b0,1'b1,16'h0005,1'b0,16'h0000,1'b0,16'h0005,1'b1,1'b1,8'd7},
        // R9: new reload, preset top
        '{1'b0,1'b0,1'b0,1'b1,16'hFFFF,1'b1,16'hABCD,1'b1,16'hFFFF,1'b0,1'b1,8'd9},
        // R3: overflow with new reload
        '{1'b1,1'b0,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'hABCD,1'b1,1'b0,8'd3},
        // R7: write, clear
        '{1'b0,1'b0,1'b1,1'b1,16'hABCD,1'b0,16'h0000,1'b1,16'hABCD,1'b0,1'b0,8'd7},
        // R4: down at reload
        '{1'b1,1'b0,1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'hFFFF,1'b1,1'b1,8'd4},
        // R7: write at top with tick, no event (toggle unchanged)
        '{1'b1,1'b0,1'b0,1'b1,16'hFFFF,1'b0,16'h0000,1'b0,16'hFFFF,1'b1,1'b1,8'd7},
        // R9: overflow uses old reload
        '{1'b1,1'b0,1'b0,1'b0,16'h0000,1'b1,16'h0042,1'b0,16'hABCD,1'b1,1'b0,8'd9},
        // R5: non-event keeps toggle
        '{1'b1,1'b0,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'hABCE,1'b1,1'b0,8'd5},
        // R7: preset zero
        '{1'b0,1'b0,1'b1,1'b1,16'h0000,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,8'd7},
        // R4: zero is not terminal when reload differs
        '{1'b1,1'b0,1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b0,16'hFFFF,1'b1,1'b0,8'd4}
    };

    task automatic drive_idle();
        tick_i = 0; dir_up_i = 0; dir_en_i = 0; cnt_we_i = 0; cnt_wdata_i = '0;
        rld_we_i = 0; rld_wdata_i = '0; flag_clr_i = 0;
    endtask

    task automatic chk(input string req, input logic [15:0] ec, input logic ef,
                       input logic et);
        checks++;
        if (count_o !== ec || irq_flag_o !== ef || wrap_tgl_o !== et) begin
            errors++;
            $display("FAIL %s: got cnt=%h flag=%b tgl=%b, expected cnt=%h flag=%b tgl=%b",
                     req, count_o, irq_flag_o, wrap_tgl_o, ec, ef, et);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles, expected at most 5000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        drive_idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset state", 16'h0000, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            tick_i      = VECS[i].tick;
            dir_up_i    = VECS[i].up;
            dir_en_i    = VECS[i].en;
            cnt_we_i    = VECS[i].cwe;
            cnt_wdata_i = VECS[i].cwd;
            rld_we_i    = VECS[i].rwe;
            rld_wdata_i = VECS[i].rwd;
            flag_clr_i  = VECS[i].clr;
            @(posedge clk);
            #1;
            chk($sformatf("R%0d R11 vector %0d", VECS[i].req, i),
                VECS[i].ecnt, VECS[i].eflag, VECS[i].etgl);
        end

        // R10: mid-run reset with tick active, then reload must be zero
        @(negedge clk);
        drive_idle();
        tick_i = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 reset beats tick", 16'h0000, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        tick_i = 1'b0;
        cnt_we_i = 1'b1;
        cnt_wdata_i = 16'hFFFF;
        @(posedge clk);
        #1;
        chk("R7 preset after reset", 16'hFFFF, 1'b0, 1'b0);
        @(negedge clk);
        cnt_we_i = 1'b0;
        tick_i = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 reload cleared by reset", 16'h0000, 1'b1, 1'b1);

        // R6: long hold with tick low
        @(negedge clk);
        drive_idle();
        repeat (5) @(posedge clk);
        #1;
        chk("R6 hold over idle cycles", 16'h0000, 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule